// File: doc/BRIEF.md
# Ethernet Receive Address Filter

The filter watches the bytes of incoming Ethernet frames as they stream past and, once per frame, gives an accept or reject verdict. It classifies the destination address as broadcast, multicast or unicast. It then tests that address against several sources: a station address (perfect match), a 512-entry hash table, up to four stored byte patterns and the ARP EtherType. A 32-bit control register chooses which of these tests may accept a frame.

The station address, the hash table bits and the pattern buffers with their counts are loaded through simple write ports. Nothing is buffered at the edge of the block. The verdict is a single-cycle pulse, `verdict_valid`, with `verdict_accept` beside it. The pulse comes as soon as the header has been seen and no enabled pattern still needs bytes, or at end-of-frame if that comes first.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset the control register reads 0 and no verdict is issued until a frame is received.
- R2: Control register bit positions: 31 enable, 30 accept broadcast, 29 accept all multicast, 28 accept all unicast, 27 perfect match, 26..23 pattern enables (bit 23 for pattern 0 up to bit 26 for pattern 3), 22 accept ARP, 21 multicast hash, 20 unicast hash, 19 U/L mask. Bits 18..0 always read 0.
- R3: A control write while bit 31 reads 1 changes only bit 31. A write while bit 31 reads 0 loads bits 31..19.
- R4: With bit 31 clear, every frame still gets a verdict pulse, and that verdict is reject.
- R5: A destination of all ones is broadcast. It is accepted exactly when bit 30 is set.
- R6: A destination is multicast when bit 0 of its first octet is 1 and it is not broadcast. It is accepted if bit 29 is set, or if bit 21 is set and its hash bit is 1. The hash index is bits 31..23 of a CRC-32 register: preset to all ones, reflected polynomial 0xEDB88320, fed the six destination octets least significant bit first, and not inverted at the end.
- R7: A unicast destination is accepted if bit 28 is set, or if bit 27 is set and it equals the station address, or if bit 20 is set and its hash bit is 1.
- R8: With bit 19 set, bit 1 of the first destination octet (the U/L bit) is left out of the station-address comparison.
- R9: Pattern k, with bit 23+k set, accepts a frame whose first n bytes equal buffer bytes 0..n-1, where n is that pattern's count. A count of 0, or a frame shorter than n bytes, never matches.
- R10: With bit 22 set, a frame whose type/length bytes 12..13 equal 0x0806 is accepted whatever its destination.
- R11: A frame of fewer than 14 bytes is rejected, and its verdict comes with its end-of-frame byte.
- R12: The verdict pulse appears in the cycle after the clock edge that takes the deciding byte. That byte is byte 14 if no enabled pattern with a nonzero count needs more bytes. Otherwise it is byte n of the longest such pattern, or the end-of-frame byte if that comes earlier. Later bytes of the frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data |
| ctrl_rdata | output | 32 | Control register contents |
| sta_we | input | 1 | Station address write strobe |
| sta_addr | input | 48 | Station address, first octet in bits 47..40 |
| hash_we | input | 1 | Hash table bit write strobe |
| hash_idx | input | 9 | Hash table bit index |
| hash_bit | input | 1 | Value written to the hash bit |
| pat_sel | input | 2 | Pattern selected for byte or count writes |
| pat_we | input | 1 | Pattern byte write strobe |
| pat_idx | input | 6 | Byte position inside the pattern buffer |
| pat_byte | input | 8 | Pattern byte value |
| cnt_we | input | 1 | Pattern count write strobe |
| cnt_val | input | 7 | Pattern byte count |
| rx_valid | input | 1 | A frame byte is present |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Frame byte |
| verdict_valid | output | 1 | One-cycle verdict pulse |
| verdict_accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
Control register writes show on `ctrl_rdata` one cycle after the write strobe, so the bench reads back at the falling edge after the strobe is removed. For every frame the bench records the cycle in which each byte was driven. It then expects exactly one verdict pulse, stamped with the cycle after the deciding byte: byte 14, the last byte a pattern needs, or the end-of-frame byte of a short frame. A verdict that comes early, late or twice is counted as a failure. Verdict outputs are sampled on falling edges, where they are settled.

// File: rtl/erf_pkg.sv
// Package: shared constants and the CRC step used by the receive filter.
// Assumes Ethernet bit order: each octet is consumed least significant bit first.
package erf_pkg;
    localparam int CTRL_W      = 32;
    localparam int B_EN        = 31;
    localparam int B_BCAST     = 30;
    localparam int B_ALL_MC    = 29;
    localparam int B_ALL_UC    = 28;
    localparam int B_PERFECT   = 27;
    localparam int B_PAT_LO    = 23;
    localparam int B_ARP       = 22;
    localparam int B_MC_HASH   = 21;
    localparam int B_UC_HASH   = 20;
    localparam int B_ULMASK    = 19;
    localparam int HDR_BYTES   = 14;
    localparam int DA_BYTES    = 6;
    localparam logic [15:0] ARP_TYPE = 16'h0806;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    // Advance a reflected CRC-32 register by one octet.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/erf_ctrl_reg.sv
// Control register of the filter. Bits 18..0 are not stored and read 0.
// While the enable bit is set, a write may change only the enable bit.
module erf_ctrl_reg
    import erf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata
);
    localparam int KEEP = CTRL_W - B_ULMASK;

    logic [KEEP-1:0] bits_q;

    // Store the control bits, locking the configuration while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bits_q <= '0;
        else if (we) begin
            if (bits_q[KEEP-1]) bits_q[KEEP-1] <= wdata[B_EN];
            else                bits_q         <= wdata[CTRL_W-1:B_ULMASK];
        end
    end

    assign rdata = {bits_q, {B_ULMASK{1'b0}}};
endmodule

// File: rtl/erf_hash_table.sv
// Single-bit-wide hash table shared by the unicast and multicast paths.
// One write port sets or clears a bit. The read is combinational.
module erf_hash_table #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic             wbit,
    input  logic [IDX_W-1:0] ridx,
    output logic             hit
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] tbl_q;

    // Write one table bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)  tbl_q       <= '0;
        else if (we) tbl_q[widx] <= wbit;
    end

    assign hit = tbl_q[ridx];
endmodule

// File: rtl/erf_pattern_unit.sv
// One pattern comparator. It holds a byte buffer and a byte count. It reports,
// for the byte being taken, whether the frame still matches after that byte
// and whether more bytes are needed. Assumes pos is the index of the byte
// being taken within the frame.
module erf_pattern_unit #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7,
    parameter int POS_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [7:0]               wr_byte,
    input  logic                     cnt_we,
    input  logic [CNT_W-1:0]         cnt_val,
    input  logic                     take,
    input  logic                     first,
    input  logic [POS_W-1:0]         pos,
    input  logic [7:0]               data,
    output logic                     hit_next,
    output logic                     wait_next
);
    localparam int IW = $clog2(DEPTH);

    logic [7:0]       mem_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             flag_next;
    logic             mismatch;
    logic [POS_W:0]   seen_next;

    // Load pattern bytes.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_byte;
    end

    // Load the pattern length.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_we) cnt_q <= cnt_val;
    end

    // Compare the current byte and work out the match state after it.
    always_comb begin
        mismatch  = (POS_W'(cnt_q) > pos) &&
                    ((pos >= POS_W'(DEPTH)) || (mem_q[pos[IW-1:0]] != data));
        flag_next = take ? ((first | flag_q) & ~mismatch) : flag_q;
        seen_next = {1'b0, pos} + 1'b1;
        hit_next  = flag_next && (cnt_q != '0) && (seen_next >= (POS_W+1)'(cnt_q));
        wait_next = (cnt_q != '0) && (seen_next < (POS_W+1)'(cnt_q));
    end

    // Keep the running match flag.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_next;
    end
endmodule

// File: rtl/eth_rx_addr_filter.sv
// Receive address filter top. It tracks the position within each frame,
// captures the destination and type bytes, runs the CRC for the hash index
// and gives one registered verdict per frame. Assumes rx_sof comes with the
// first valid byte. Bytes after the verdict are ignored until the next rx_sof.
module eth_rx_addr_filter
    import erf_pkg::*;
#(
    parameter int PAT_NUM    = 4,
    parameter int PAT_DEPTH  = 64,
    parameter int PAT_CNT_W  = 7,
    parameter int HASH_IDX_W = 9,
    parameter int POS_W      = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ctrl_we,
    input  logic [31:0]                  ctrl_wdata,
    output logic [31:0]                  ctrl_rdata,
    input  logic                         sta_we,
    input  logic [47:0]                  sta_addr,
    input  logic                         hash_we,
    input  logic [HASH_IDX_W-1:0]        hash_idx,
    input  logic                         hash_bit,
    input  logic [$clog2(PAT_NUM)-1:0]   pat_sel,
    input  logic                         pat_we,
    input  logic [$clog2(PAT_DEPTH)-1:0] pat_idx,
    input  logic [7:0]                   pat_byte,
    input  logic                         cnt_we,
    input  logic [PAT_CNT_W-1:0]         cnt_val,
    input  logic                         rx_valid,
    input  logic                         rx_sof,
    input  logic                         rx_eof,
    input  logic [7:0]                   rx_data,
    output logic                         verdict_valid,
    output logic                         verdict_accept
);
    localparam logic [47:0] UL_BIT   = 48'h0200_0000_0000;
    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [31:0]        ctrl;
    logic [47:0]        sta_q, da_q, da_n;
    logic [15:0]        ty_q, ty_n;
    logic [31:0]        crc_q, crc_n;
    logic [POS_W-1:0]   pos_q, cur_pos, seen_n;
    logic               done_q;
    logic               take, decide, accept;
    logic               is_bc, is_mc, hash_hit, pm_hit;
    logic [PAT_NUM-1:0] pat_hit, pat_wait, pat_en;

    erf_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata), .rdata(ctrl)
    );
    assign ctrl_rdata = ctrl;

    erf_hash_table #(.IDX_W(HASH_IDX_W)) u_hash (
        .clk(clk), .rst_n(rst_n), .we(hash_we), .widx(hash_idx), .wbit(hash_bit),
        .ridx(crc_n[31 -: HASH_IDX_W]), .hit(hash_hit)
    );

    // Hold the station address.
    always_ff @(posedge clk) begin
        if (!rst_n)      sta_q <= '0;
        else if (sta_we) sta_q <= sta_addr;
    end

    assign take    = rx_valid & (rx_sof | ~done_q);
    assign cur_pos = rx_sof ? '0 : pos_q;
    assign seen_n  = (cur_pos == POS_MAX) ? POS_MAX : cur_pos + 1'b1;
    assign pat_en  = ctrl[B_PAT_LO +: PAT_NUM];

    for (genvar k = 0; k < PAT_NUM; k++) begin : g_pat
        erf_pattern_unit #(.DEPTH(PAT_DEPTH), .CNT_W(PAT_CNT_W), .POS_W(POS_W)) u_pat (
            .clk(clk), .rst_n(rst_n),
            .wr_en(pat_we && (pat_sel == k)), .wr_idx(pat_idx), .wr_byte(pat_byte),
            .cnt_we(cnt_we && (pat_sel == k)), .cnt_val(cnt_val),
            .take(take), .first(rx_sof), .pos(cur_pos), .data(rx_data),
            .hit_next(pat_hit[k]), .wait_next(pat_wait[k])
        );
    end

    // Next header state after the byte being taken.
    always_comb begin
        da_n  = da_q;
        ty_n  = ty_q;
        crc_n = crc_q;
        if (take) begin
            if (cur_pos < POS_W'(DA_BYTES)) begin
                da_n  = {da_q[39:0], rx_data};
                crc_n = crc_step(rx_sof ? 32'hFFFF_FFFF : crc_q, rx_data);
            end
            if (cur_pos == POS_W'(12)) ty_n[15:8] = rx_data;
            if (cur_pos == POS_W'(13)) ty_n[7:0]  = rx_data;
        end
    end

    // Classify the destination and form the verdict.
    always_comb begin
        is_bc  = &da_n;
        is_mc  = da_n[40] & ~is_bc;
        pm_hit = ((da_n ^ sta_q) & (ctrl[B_ULMASK] ? ~UL_BIT : '1)) == '0;
        decide = take & (rx_eof | ((seen_n >= POS_W'(HDR_BYTES)) & ~|(pat_wait & pat_en)));
        accept = ctrl[B_EN] & (seen_n >= POS_W'(HDR_BYTES)) & (
                   (ctrl[B_ARP] & (ty_n == ARP_TYPE))
                 | (|(pat_hit & pat_en))
                 | (is_bc & ctrl[B_BCAST])
                 | (is_mc & (ctrl[B_ALL_MC] | (ctrl[B_MC_HASH] & hash_hit)))
                 | (~is_bc & ~is_mc & (ctrl[B_ALL_UC] | (ctrl[B_PERFECT] & pm_hit)
                                       | (ctrl[B_UC_HASH] & hash_hit))));
    end

    // Register frame progress and the verdict pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q          <= '0;
            done_q         <= 1'b1;
            da_q           <= '0;
            ty_q           <= '0;
            crc_q          <= '1;
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
        end else begin
            da_q           <= da_n;
            ty_q           <= ty_n;
            crc_q          <= crc_n;
            verdict_valid  <= decide;
            verdict_accept <= decide & accept;
            if (take) begin
                pos_q  <= seen_n;
                done_q <= decide;
            end
        end
    end
endmodule

// File: rtl/erf_checker.sv
// Property checker for the receive filter, bound to the top module.
// Observes only ports.
module erf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctrl_rdata,
    input logic        rx_valid,
    input logic        verdict_valid,
    input logic        verdict_accept
);
    // R2: unused low bits always read zero.
    assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[18:0] == 19'd0);

    // R3: configuration bits hold while the filter is enabled.
    assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[31] |=> $stable(ctrl_rdata[30:19]));

    // R4: a verdict decided while disabled is a reject.
    assert_off_rejects_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && !$past(ctrl_rdata[31])) |-> !verdict_accept);

    // R12: an accept only travels with a verdict pulse.
    assert_accept_in_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_accept |-> verdict_valid);

    // R12: a verdict follows a cycle that carried a byte.
    assert_verdict_after_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> $past(rx_valid));
endmodule

bind eth_rx_addr_filter erf_checker u_erf_checker (
    .clk(clk), .rst_n(rst_n), .ctrl_rdata(ctrl_rdata), .rx_valid(rx_valid),
    .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
);

// File: tb/test_eth_rx_addr_filter.sv
// Directed bench for the receive address filter: one task per scenario.
module test_eth_rx_addr_filter;
    localparam logic [31:0] C_EN  = 32'h8000_0000, C_BC  = 32'h4000_0000,
                            C_AMC = 32'h2000_0000, C_AUC = 32'h1000_0000,
                            C_PM  = 32'h0800_0000, C_P0  = 32'h0080_0000,
                            C_ARP = 32'h0040_0000, C_MH  = 32'h0020_0000,
                            C_UH  = 32'h0010_0000, C_ULM = 32'h0008_0000;
    localparam logic [47:0] STA  = 48'h00AA_BBCC_DDEE;
    localparam logic [47:0] STA2 = 48'h02AA_BBCC_DDEE;
    localparam logic [47:0] UCX  = 48'h0011_2233_4455;
    localparam logic [47:0] MCA  = 48'h0100_5E00_0001;
    localparam logic [47:0] BCA  = 48'hFFFF_FFFF_FFFF;

    logic clk = 0, rst_n = 0;
    logic ctrl_we = 0, sta_we = 0, hash_we = 0, hash_bit = 0, pat_we = 0, cnt_we = 0;
    logic [31:0] ctrl_wdata = 0, ctrl_rdata;
    logic [47:0] sta_addr = 0;
    logic [8:0]  hash_idx = 0;
    logic [1:0]  pat_sel = 0;
    logic [5:0]  pat_idx = 0;
    logic [7:0]  pat_byte = 0, rx_data = 0;
    logic [6:0]  cnt_val = 0;
    logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
    logic verdict_valid, verdict_accept;

    int checks = 0, errors = 0, cyc = 0, nverd = 0, vcyc = 0;
    logic vacc = 0;
    logic [7:0] fr [0:79];
    int dcyc [0:79];

    eth_rx_addr_filter i_eth_rx_addr_filter (.*);

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Record each verdict pulse at the falling edge.
    always @(negedge clk) if (verdict_valid) begin
        nverd++; vcyc = cyc; vacc = verdict_accept;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] hidx(input logic [47:0] da);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int o = 0; o < 6; o++)
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ da[47 - 8*o - 7 + b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        return c[31:23];
    endfunction

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 0;
    endtask

    task automatic cfg(input logic [31:0] v);
        wr_ctrl(32'h0); wr_ctrl(v);
    endtask

    task automatic set_hash(input logic [8:0] i, input logic b);
        @(negedge clk); hash_we = 1; hash_idx = i; hash_bit = b;
        @(negedge clk); hash_we = 0;
    endtask

    task automatic build(input logic [47:0] da, input logic [15:0] ty, input int len);
        for (int i = 0; i < len; i++)
            if (i < 6)       fr[i] = da[47 - 8*i -: 8];
            else if (i < 12) fr[i] = 8'h10 + 8'(i);
            else if (i == 12) fr[i] = ty[15:8];
            else if (i == 13) fr[i] = ty[7:0];
            else             fr[i] = 8'(i * 3);
    endtask

    task automatic send(input int len);
        nverd = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_data = fr[i]; dcyc[i] = cyc;
        end
        @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_v(input string req, input logic acc, input int idx);
        chk({req, " verdict count"}, nverd, 1);
        chk({req, " accept"}, vacc, acc);
        chk({req, " verdict cycle"}, vcyc, dcyc[idx] + 1);
    endtask

    task automatic t_reset;
        chk("R1 ctrl after reset", ctrl_rdata, 0);
        repeat (3) @(negedge clk);
        chk("R1 no verdict idle", nverd, 0);
    endtask

    task automatic t_ctrl;
        wr_ctrl(32'hFFFF_FFFF); chk("R2 load all", ctrl_rdata, 32'hFFF8_0000);
        wr_ctrl(32'h0);         chk("R3 locked write", ctrl_rdata, 32'h7FF8_0000);
        wr_ctrl(32'h0);         chk("R3 unlocked write", ctrl_rdata, 0);
        wr_ctrl(C_EN);          chk("R2 enable", ctrl_rdata, C_EN);
        wr_ctrl(C_EN | C_BC);   chk("R3 ignored while on", ctrl_rdata, C_EN);
    endtask

    task automatic t_disabled;
        cfg(C_BC); build(BCA, 16'h0800, 20); send(20); expect_v("R4 disabled", 0, 13);
    endtask

    task automatic t_bcast;
        cfg(C_EN | C_BC); build(BCA, 16'h0800, 30); send(30); expect_v("R5 bc on R12", 1, 13);
        cfg(C_EN | C_AMC | C_AUC); send(30); expect_v("R5 bc off", 0, 13);
    endtask

    task automatic t_mcast;
        build(MCA, 16'h0800, 20);
        cfg(C_EN | C_AMC); send(20); expect_v("R6 all mc", 1, 13);
        cfg(C_EN | C_MH);  send(20); expect_v("R6 hash clear", 0, 13);
        set_hash(hidx(MCA), 1); send(20); expect_v("R6 hash hit", 1, 13);
        cfg(C_EN | C_UH);  send(20); expect_v("R6 uc hash not for mc", 0, 13);
        set_hash(hidx(MCA), 0);
    endtask

    task automatic t_ucast;
        @(negedge clk); sta_we = 1; sta_addr = STA; @(negedge clk); sta_we = 0;
        build(STA, 16'h0800, 20);
        cfg(C_EN | C_PM);  send(20); expect_v("R7 perfect", 1, 13);
        build(UCX, 16'h0800, 20);
        send(20);          expect_v("R7 perfect miss", 0, 13);
        cfg(C_EN | C_AUC); send(20); expect_v("R7 all uc", 1, 13);
        cfg(C_EN | C_UH);  set_hash(hidx(UCX), 1);
        send(20);          expect_v("R7 uc hash", 1, 13);
        set_hash(hidx(UCX), 0);
    endtask

    task automatic t_ulmask;
        build(STA2, 16'h0800, 20);
        cfg(C_EN | C_PM);         send(20); expect_v("R8 U/L compared", 0, 13);
        cfg(C_EN | C_PM | C_ULM); send(20); expect_v("R8 U/L masked", 1, 13);
    endtask

    task automatic t_pattern;
        build(UCX, 16'h0800, 30);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); pat_we = 1; pat_sel = 0; pat_idx = 6'(i); pat_byte = fr[i];
        end
        @(negedge clk); pat_we = 0; cnt_we = 1; cnt_val = 7'd20;
        @(negedge clk); cnt_we = 0;
        cfg(C_EN | C_P0); send(30); expect_v("R9 pattern R12", 1, 19);
        send(18);                   expect_v("R9 frame too short R12 eof", 0, 17);
        fr[16] = fr[16] ^ 8'h01; send(30); expect_v("R9 pattern miss", 0, 19);
        @(negedge clk); cnt_we = 1; cnt_val = 7'd0;
        @(negedge clk); cnt_we = 0;
        build(UCX, 16'h0800, 30); send(30); expect_v("R9 count zero", 0, 13);
    endtask

    task automatic t_arp;
        build(UCX, 16'h0806, 20);
        cfg(C_EN | C_ARP); send(20); expect_v("R10 arp bypass", 1, 13);
        cfg(C_EN);         send(20); expect_v("R10 arp off", 0, 13);
        build(UCX, 16'h0800, 20);
        cfg(C_EN | C_ARP); send(20); expect_v("R10 not arp", 0, 13);
    endtask

    task automatic t_short;
        cfg(C_EN | C_BC); build(BCA, 16'h0806, 10); send(10);
        expect_v("R11 short R12 eof", 0, 9);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset; t_ctrl; t_disabled; t_bcast; t_mcast;
        t_ucast; t_ulmask; t_pattern; t_arp; t_short;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule